// File: doc/BRIEF.md
# Idle Power State Sequencer

This block decides when a multi-core processor package may drop into an idle power state, and in what order the package leaves it again. It watches a halted flag from every core. While any core is still running the package stays in normal operation. Once every core reports halted, the package moves to a plain halt state. If the extended mode is enabled, it instead runs a short sequence that lowers the core clock ratio and the voltage code and then rests in extended halt. A wake-up event (management interrupt, init, NMI or INTR) takes the package back out. In the extended case the exit sequence restores the operating point in the reverse order of entry.

Each change of the operating point is a request/acknowledge handshake with outside clocking and regulation logic. The sequencer keeps a request and its value steady until the acknowledge arrives. Before it lowers anything, it saves the current ratio and voltage code and the low-power targets. The exit path restores the saved values. A stop-clock request that arrives during plain halt parks the package in a stop-grant state, and the package returns to halt when the request drops. Snoops are served in both halt states. A return from a management interrupt handler can ask for the package to go back into halt.

FSM states: NORM, HALT, SGNT (stop grant), XE_RATIO and XE_VCODE (extended entry steps), XHALT (extended halt), XX_VCODE and XX_RATIO (extended exit steps). Transitions: NORM→HALT or NORM→XE_RATIO on entry; HALT→NORM on wake; HALT→SGNT and SGNT→HALT on stop-clock; XE_RATIO→XE_VCODE, XE_VCODE→XHALT, XHALT→XX_VCODE, XX_VCODE→XX_RATIO, XX_RATIO→NORM on acknowledges and wake; XE_RATIO→XX_RATIO and XE_VCODE→XX_VCODE on a wake held over from the entry.

Top module: `idle_pwr_seq`

## Requirements
- R1: While at least one core flag is low and no halt-return request is present, the package stays in normal state.
- R2: In HALT, any wake line takes the state to normal at the next edge. A wake outranks a stop-clock request in the same cycle. A wake present in normal state blocks entry in that same cycle.
- R3: An active-low reset acts at once, without waiting for a clock. It forces normal state and drops both change requests.
- R4: A stop-clock request in HALT leads to stop-grant. Wake lines are ignored in stop-grant. When the request drops, the state returns to HALT, not to normal.
- R5: Entry goes to plain HALT when the extended enable is 0 and to the extended entry sequence when it is 1.
- R6: Extended entry first raises the ratio request with the low ratio. Only after the ratio acknowledge does it raise the voltage request with the low code. The two requests are never high together, and a request and its value stay steady until acknowledged.
- R7: A wake in extended halt first raises the voltage request with the saved code. After the acknowledge it raises the ratio request with the saved ratio, and after that acknowledge it returns to normal.
- R8: A wake during extended entry is held. If it comes in the ratio step, the ratio acknowledge leads straight to the ratio restore. If it comes in the voltage step, the voltage acknowledge leads to the voltage restore.
- R9: The current ratio, current code and low targets are captured when extended entry starts. Later changes on those inputs do not affect the values the sequence drives.
- R10: The snoop grant follows the snoop request in the same cycle while in HALT or extended halt, and is 0 in every other state.
- R11: In normal state, a handler-return pulse with the halt flag set starts entry (plain or extended per R5). With the flag clear, the state stays normal.
- R12: The state output uses 0 normal, 1 halt, 2 stop-grant, 3 extended entry, 4 extended halt, 5 extended exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_halted | input | NCORES | One halted flag per core |
| brk_mgmt | input | 1 | Management interrupt wake |
| brk_init | input | 1 | Init request wake |
| brk_nmi | input | 1 | Non-maskable interrupt wake |
| brk_intr | input | 1 | Maskable interrupt wake |
| mgmt_ret_valid | input | 1 | Handler return pulse |
| mgmt_ret_to_halt | input | 1 | Handler return resumes in halt when 1 |
| stop_req | input | 1 | Stop-clock request |
| ext_en | input | 1 | Extended low-power mode enable |
| cur_ratio | input | RATIO_W | Present core clock ratio |
| low_ratio | input | RATIO_W | Ratio used in extended halt |
| cur_vcode | input | VCODE_W | Present voltage code |
| low_vcode | input | VCODE_W | Voltage code used in extended halt |
| ratio_ack | input | 1 | Ratio change done |
| vcode_ack | input | 1 | Voltage change done |
| snoop_req | input | 1 | Snoop request |
| ratio_req | output | 1 | Ratio change request |
| ratio_val | output | RATIO_W | Requested ratio |
| vcode_req | output | 1 | Voltage change request |
| vcode_val | output | VCODE_W | Requested voltage code |
| state_code | output | 3 | Package power state |
| snoop_grant | output | 1 | Snoop may be serviced |

## Verification
Two pairs of events can fall in the same cycle. A wake can coincide with a stop-clock request in HALT, and with the all-halted condition in normal state. A wake can also coincide with the step acknowledge in an extended entry, where it must be held and then change the next step. The bench raises the wake line in the same cycle as the competing stop-clock request or entry condition, and also during a step with a delayed acknowledge. A behavioural model compares the state code, both requests and their values, and the snoop grant every cycle.

// File: rtl/ips_pkg.sv
package ips_pkg;

    typedef enum logic [2:0] {
        ST_NORM,
        ST_HALT,
        ST_SGNT,
        ST_XE_RATIO,
        ST_XE_VCODE,
        ST_XHALT,
        ST_XX_VCODE,
        ST_XX_RATIO
    } ips_state_e;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] CODE_NORMAL = 3'd0;
    localparam logic [CODE_W-1:0] CODE_HALT   = 3'd1;
    localparam logic [CODE_W-1:0] CODE_SGNT   = 3'd2;
    localparam logic [CODE_W-1:0] CODE_XENTRY = 3'd3;
    localparam logic [CODE_W-1:0] CODE_XHALT  = 3'd4;
    localparam logic [CODE_W-1:0] CODE_XEXIT  = 3'd5;

endpackage

// File: rtl/ips_break_unit.sv
module ips_break_unit #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] brk_vec,
    input  logic            in_entry,
    output logic            brk_now,
    output logic            brk_eff
);

    logic pend_q;

    assign brk_now = |brk_vec;
    assign brk_eff = brk_now | pend_q;

    // A wake seen during the entry steps is held until the entry ends.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!in_entry) begin
            pend_q <= 1'b0;
        end else if (brk_now) begin
            pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ips_oppt_regs.sv
module ips_oppt_regs #(
    parameter int RATIO_W = 6,
    parameter int VCODE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic [RATIO_W-1:0] cur_ratio,
    input  logic [RATIO_W-1:0] low_ratio,
    input  logic [VCODE_W-1:0] cur_vcode,
    input  logic [VCODE_W-1:0] low_vcode,
    output logic [RATIO_W-1:0] keep_ratio,
    output logic [RATIO_W-1:0] tgt_ratio,
    output logic [VCODE_W-1:0] keep_vcode,
    output logic [VCODE_W-1:0] tgt_vcode
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_ratio <= '0;
            tgt_ratio  <= '0;
            keep_vcode <= '0;
            tgt_vcode  <= '0;
        end else if (cap) begin
            keep_ratio <= cur_ratio;
            tgt_ratio  <= low_ratio;
            keep_vcode <= cur_vcode;
            tgt_vcode  <= low_vcode;
        end
    end

endmodule

// File: rtl/ips_fsm.sv
module ips_fsm
    import ips_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              all_halted,
    input  logic              brk_now,
    input  logic              brk_eff,
    input  logic              ret_to_halt,
    input  logic              stop_req,
    input  logic              ext_en,
    input  logic              ratio_ack,
    input  logic              vcode_ack,
    input  logic              snoop_req,
    output logic              save_en,
    output logic              in_entry,
    output logic              ratio_req,
    output logic              ratio_low,
    output logic              vcode_req,
    output logic              vcode_low,
    output logic [CODE_W-1:0] state_code,
    output logic              snoop_grant
);

    ips_state_e state_q, state_d;
    logic       go_idle;

    assign go_idle = !brk_now && (all_halted || ret_to_halt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORM:     if (go_idle) state_d = ext_en ? ST_XE_RATIO : ST_HALT;
            ST_HALT:     if (brk_now) state_d = ST_NORM;
                         else if (stop_req) state_d = ST_SGNT;
            ST_SGNT:     if (!stop_req) state_d = ST_HALT;
            ST_XE_RATIO: if (ratio_ack) state_d = brk_eff ? ST_XX_RATIO : ST_XE_VCODE;
            ST_XE_VCODE: if (vcode_ack) state_d = brk_eff ? ST_XX_VCODE : ST_XHALT;
            ST_XHALT:    if (brk_now) state_d = ST_XX_VCODE;
            ST_XX_VCODE: if (vcode_ack) state_d = ST_XX_RATIO;
            ST_XX_RATIO: if (ratio_ack) state_d = ST_NORM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORM;
        else        state_q <= state_d;
    end

    always_comb begin
        save_en     = (state_q == ST_NORM) && go_idle && ext_en;
        in_entry    = 1'b0;
        ratio_req   = 1'b0;
        ratio_low   = 1'b0;
        vcode_req   = 1'b0;
        vcode_low   = 1'b0;
        snoop_grant = 1'b0;
        state_code  = CODE_NORMAL;
        unique case (state_q)
            ST_NORM:     state_code = CODE_NORMAL;
            ST_HALT: begin
                state_code  = CODE_HALT;
                snoop_grant = snoop_req;
            end
            ST_SGNT:     state_code = CODE_SGNT;
            ST_XE_RATIO: begin
                state_code = CODE_XENTRY;
                in_entry   = 1'b1;
                ratio_req  = 1'b1;
                ratio_low  = 1'b1;
            end
            ST_XE_VCODE: begin
                state_code = CODE_XENTRY;
                in_entry   = 1'b1;
                vcode_req  = 1'b1;
                vcode_low  = 1'b1;
            end
            ST_XHALT: begin
                state_code  = CODE_XHALT;
                snoop_grant = snoop_req;
            end
            ST_XX_VCODE: begin
                state_code = CODE_XEXIT;
                vcode_req  = 1'b1;
            end
            ST_XX_RATIO: begin
                state_code = CODE_XEXIT;
                ratio_req  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/idle_pwr_seq.sv
module idle_pwr_seq #(
    parameter int NCORES  = 2,
    parameter int RATIO_W = 6,
    parameter int VCODE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCORES-1:0]  core_halted,
    input  logic               brk_mgmt,
    input  logic               brk_init,
    input  logic               brk_nmi,
    input  logic               brk_intr,
    input  logic               mgmt_ret_valid,
    input  logic               mgmt_ret_to_halt,
    input  logic               stop_req,
    input  logic               ext_en,
    input  logic [RATIO_W-1:0] cur_ratio,
    input  logic [RATIO_W-1:0] low_ratio,
    input  logic [VCODE_W-1:0] cur_vcode,
    input  logic [VCODE_W-1:0] low_vcode,
    input  logic               ratio_ack,
    input  logic               vcode_ack,
    input  logic               snoop_req,
    output logic               ratio_req,
    output logic [RATIO_W-1:0] ratio_val,
    output logic               vcode_req,
    output logic [VCODE_W-1:0] vcode_val,
    output logic [2:0]         state_code,
    output logic               snoop_grant
);

    localparam int NBRK = 4;

    logic [NBRK-1:0]    brk_vec;
    logic               brk_now, brk_eff;
    logic               save_en, in_entry, ratio_low, vcode_low;
    logic [RATIO_W-1:0] keep_ratio, tgt_ratio;
    logic [VCODE_W-1:0] keep_vcode, tgt_vcode;

    assign brk_vec = {brk_mgmt, brk_init, brk_nmi, brk_intr};

    ips_break_unit #(.NSRC(NBRK)) u_brk (
        .clk      (clk),
        .rst_n    (rst_n),
        .brk_vec  (brk_vec),
        .in_entry (in_entry),
        .brk_now  (brk_now),
        .brk_eff  (brk_eff)
    );

    ips_oppt_regs #(.RATIO_W(RATIO_W), .VCODE_W(VCODE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (save_en),
        .cur_ratio  (cur_ratio),
        .low_ratio  (low_ratio),
        .cur_vcode  (cur_vcode),
        .low_vcode  (low_vcode),
        .keep_ratio (keep_ratio),
        .tgt_ratio  (tgt_ratio),
        .keep_vcode (keep_vcode),
        .tgt_vcode  (tgt_vcode)
    );

    ips_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_halted  (&core_halted),
        .brk_now     (brk_now),
        .brk_eff     (brk_eff),
        .ret_to_halt (mgmt_ret_valid && mgmt_ret_to_halt),
        .stop_req    (stop_req),
        .ext_en      (ext_en),
        .ratio_ack   (ratio_ack),
        .vcode_ack   (vcode_ack),
        .snoop_req   (snoop_req),
        .save_en     (save_en),
        .in_entry    (in_entry),
        .ratio_req   (ratio_req),
        .ratio_low   (ratio_low),
        .vcode_req   (vcode_req),
        .vcode_low   (vcode_low),
        .state_code  (state_code),
        .snoop_grant (snoop_grant)
    );

    assign ratio_val = ratio_low ? tgt_ratio : keep_ratio;
    assign vcode_val = vcode_low ? tgt_vcode : keep_vcode;

endmodule

// File: rtl/ips_checker.sv
module ips_checker #(
    parameter int NCORES  = 2,
    parameter int RATIO_W = 6,
    parameter int VCODE_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NCORES-1:0]  core_halted,
    input logic               brk_mgmt,
    input logic               brk_init,
    input logic               brk_nmi,
    input logic               brk_intr,
    input logic               mgmt_ret_valid,
    input logic               mgmt_ret_to_halt,
    input logic               stop_req,
    input logic               ext_en,
    input logic               ratio_ack,
    input logic               vcode_ack,
    input logic               snoop_req,
    input logic               ratio_req,
    input logic [RATIO_W-1:0] ratio_val,
    input logic               vcode_req,
    input logic [VCODE_W-1:0] vcode_val,
    input logic [2:0]         state_code,
    input logic               snoop_grant
);

    logic wake;
    assign wake = brk_mgmt | brk_init | brk_nmi | brk_intr;

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r3_reset_state: assert (state_code == 3'd0 && !ratio_req && !vcode_req);
        end
    end

    a_r1_stay_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0 && !(&core_halted) && !(mgmt_ret_valid && mgmt_ret_to_halt))
        |=> state_code == 3'd0);

    a_r2_wake_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && wake) |=> state_code == 3'd0);

    a_r4_sgnt_back_to_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2 && !stop_req) |=> state_code == 3'd1);

    a_r4_sgnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2 && stop_req) |=> state_code == 3'd2);

    a_r5_plain_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0 && !ext_en && (&core_halted) && !wake) |=> state_code == 3'd1);

    a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(ratio_req && vcode_req));

    a_r6_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_req && !ratio_ack) |=> (ratio_req && $stable(ratio_val)));

    a_r6_vcode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode_req && !vcode_ack) |=> (vcode_req && $stable(vcode_val)));

    a_r7_voltage_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4 && wake) |=> (vcode_req && !ratio_req));

    a_r10_snoop_window: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_grant |-> (snoop_req && (state_code == 3'd1 || state_code == 3'd4)));

    a_r12_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 3'd5);

endmodule

bind idle_pwr_seq ips_checker #(
    .NCORES  (NCORES),
    .RATIO_W (RATIO_W),
    .VCODE_W (VCODE_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .core_halted      (core_halted),
    .brk_mgmt         (brk_mgmt),
    .brk_init         (brk_init),
    .brk_nmi          (brk_nmi),
    .brk_intr         (brk_intr),
    .mgmt_ret_valid   (mgmt_ret_valid),
    .mgmt_ret_to_halt (mgmt_ret_to_halt),
    .stop_req         (stop_req),
    .ext_en           (ext_en),
    .ratio_ack        (ratio_ack),
    .vcode_ack        (vcode_ack),
    .snoop_req        (snoop_req),
    .ratio_req        (ratio_req),
    .ratio_val        (ratio_val),
    .vcode_req        (vcode_req),
    .vcode_val        (vcode_val),
    .state_code       (state_code),
    .snoop_grant      (snoop_grant)
);

// File: tb/idle_pwr_seq_test.sv
`timescale 1ns/1ps
module idle_pwr_seq_test;

    localparam int NC = 2;
    localparam int RW = 6;
    localparam int VW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] core_halted = '0;
    logic          brk_mgmt = 0, brk_init = 0, brk_nmi = 0, brk_intr = 0;
    logic          mgmt_ret_valid = 0, mgmt_ret_to_halt = 0;
    logic          stop_req = 0, ext_en = 0, snoop_req = 0;
    logic [RW-1:0] cur_ratio = '0, low_ratio = '0;
    logic [VW-1:0] cur_vcode = '0, low_vcode = '0;
    logic          ratio_ack = 0, vcode_ack = 0;
    logic          ratio_req, vcode_req, snoop_grant;
    logic [RW-1:0] ratio_val;
    logic [VW-1:0] vcode_val;
    logic [2:0]    state_code;

    int checks = 0;
    int fails  = 0;
    int ack_dly = 1;
    int rcnt = 0, vcnt = 0;
    string tag = "R3";

    always #10 clk = ~clk;

    idle_pwr_seq #(.NCORES(NC), .RATIO_W(RW), .VCODE_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .core_halted(core_halted),
        .brk_mgmt(brk_mgmt), .brk_init(brk_init), .brk_nmi(brk_nmi), .brk_intr(brk_intr),
        .mgmt_ret_valid(mgmt_ret_valid), .mgmt_ret_to_halt(mgmt_ret_to_halt),
        .stop_req(stop_req), .ext_en(ext_en),
        .cur_ratio(cur_ratio), .low_ratio(low_ratio), .cur_vcode(cur_vcode), .low_vcode(low_vcode),
        .ratio_ack(ratio_ack), .vcode_ack(vcode_ack), .snoop_req(snoop_req),
        .ratio_req(ratio_req), .ratio_val(ratio_val), .vcode_req(vcode_req), .vcode_val(vcode_val),
        .state_code(state_code), .snoop_grant(snoop_grant)
    );

    // Acknowledge responder: one-cycle ack after ack_dly cycles of request.
    always @(negedge clk) begin
        if (ratio_req && !ratio_ack) begin
            if (rcnt >= ack_dly) begin ratio_ack <= 1'b1; rcnt <= 0; end
            else rcnt <= rcnt + 1;
        end else begin
            ratio_ack <= 1'b0; rcnt <= 0;
        end
        if (vcode_req && !vcode_ack) begin
            if (vcnt >= ack_dly) begin vcode_ack <= 1'b1; vcnt <= 0; end
            else vcnt <= vcnt + 1;
        end else begin
            vcode_ack <= 1'b0; vcnt <= 0;
        end
    end

    // Behavioural reference: 0 norm,1 halt,2 sgnt,3 entry-ratio,4 entry-volt,
    // 5 ext halt,6 exit-volt,7 exit-ratio.
    int m_st = 0;
    bit m_hold = 0;
    int m_kr = 0, m_kv = 0, m_lr = 0, m_lv = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_hold = 0; m_kr = 0; m_kv = 0; m_lr = 0; m_lv = 0;
        end else begin
            bit w;
            bit was_entry;
            int nx;
            w = brk_mgmt || brk_init || brk_nmi || brk_intr;
            was_entry = (m_st == 3 || m_st == 4);
            nx = m_st;
            if (m_st == 0) begin
                if (!w && ((&core_halted) || (mgmt_ret_valid && mgmt_ret_to_halt))) begin
                    if (ext_en) begin
                        m_kr = cur_ratio; m_kv = cur_vcode; m_lr = low_ratio; m_lv = low_vcode;
                        nx = 3;
                    end else nx = 1;
                end
            end else if (m_st == 1) begin
                if (w) nx = 0; else if (stop_req) nx = 2;
            end else if (m_st == 2) begin
                if (!stop_req) nx = 1;
            end else if (m_st == 3) begin
                if (ratio_ack) nx = (w || m_hold) ? 7 : 4;
            end else if (m_st == 4) begin
                if (vcode_ack) nx = (w || m_hold) ? 6 : 5;
            end else if (m_st == 5) begin
                if (w) nx = 6;
            end else if (m_st == 6) begin
                if (vcode_ack) nx = 7;
            end else begin
                if (ratio_ack) nx = 0;
            end
            m_hold = was_entry ? (m_hold || w) : 1'b0;
            m_st = nx;
        end
    end

    function automatic int code_of(int s);
        if (s == 3 || s == 4) return 3;
        if (s == 5) return 4;
        if (s == 6 || s == 7) return 5;
        return s;
    endfunction

    task automatic chk(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    // Cycle compare against the reference, a quarter period after the edge.
    always @(posedge clk) begin
        #5;
        begin
            int ec;
            bit er, ev, eg;
            ec = code_of(m_st);
            er = (m_st == 3 || m_st == 7);
            ev = (m_st == 4 || m_st == 6);
            eg = snoop_req && (m_st == 1 || m_st == 5);
            chk(state_code == ec, {tag, " R12 state"}, state_code, ec);
            chk(ratio_req == er && vcode_req == ev, {tag, " R6 requests"},
                {ratio_req, vcode_req}, {er, ev});
            if (er) chk(ratio_val == ((m_st == 3) ? m_lr : m_kr), {tag, " R9 ratio value"},
                        ratio_val, (m_st == 3) ? m_lr : m_kr);
            if (ev) chk(vcode_val == ((m_st == 4) ? m_lv : m_kv), {tag, " R9 code value"},
                        vcode_val, (m_st == 4) ? m_lv : m_kv);
            chk(snoop_grant == eg, {tag, " R10 snoop"}, snoop_grant, eg);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_code(int c);
        for (int i = 0; i < 60 && state_code != c; i++) @(negedge clk);
    endtask

    task automatic wait_vreq();
        for (int i = 0; i < 60 && !vcode_req; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        cur_ratio = 6'd20; cur_vcode = 7'd50; low_ratio = 6'd8; low_vcode = 7'd30;
        step(3);
        tag = "R3";
        chk(state_code == 0 && !ratio_req && !vcode_req, "R3 reset state", state_code, 0);
        rst_n = 1'b1;

        // R1: one core halted keeps normal
        tag = "R1";
        core_halted = 2'b01;
        step(4);
        chk(state_code == 0, "R1 partial halt", state_code, 0);

        // R5: plain entry
        tag = "R5";
        core_halted = 2'b11;
        step(1);
        step(1);
        chk(state_code == 1, "R5 plain halt", state_code, 1);

        // R10 snoop in halt
        tag = "R10";
        snoop_req = 1'b1;
        step(1);
        chk(snoop_grant == 1, "R10 grant in halt", snoop_grant, 1);
        snoop_req = 1'b0;

        // R4 stop grant, wake ignored, return to halt
        tag = "R4";
        stop_req = 1'b1;
        step(1);
        step(1);
        chk(state_code == 2, "R4 stop grant", state_code, 2);
        brk_nmi = 1'b1;
        step(1);
        brk_nmi = 1'b0;
        step(1);
        chk(state_code == 2, "R4 wake ignored", state_code, 2);
        stop_req = 1'b0;
        step(1);
        step(1);
        chk(state_code == 1, "R4 back to halt", state_code, 1);

        // R2: wake and stop-clock together, wake wins
        tag = "R2";
        brk_intr = 1'b1; stop_req = 1'b1; core_halted = 2'b00;
        step(1);
        brk_intr = 1'b0; stop_req = 1'b0;
        step(1);
        chk(state_code == 0, "R2 wake beats stop", state_code, 0);

        // R2: wake with entry condition blocks entry
        core_halted = 2'b11; brk_init = 1'b1;
        step(1);
        core_halted = 2'b00; brk_init = 1'b0;
        step(1);
        chk(state_code == 0, "R2 wake blocks entry", state_code, 0);

        // R6/R7/R9: full extended cycle
        tag = "R7";
        ext_en = 1'b1; ack_dly = 2;
        core_halted = 2'b11;
        step(1);
        step(1);
        chk(state_code == 3 && ratio_req && !vcode_req, "R6 ratio first", state_code, 3);
        chk(ratio_val == 8, "R6 low ratio", ratio_val, 8);
        cur_ratio = 6'd25; cur_vcode = 7'd60; low_ratio = 6'd4;
        wait_vreq();
        chk(vcode_val == 30 && !ratio_req, "R6 low code second", vcode_val, 30);
        wait_code(4);
        chk(state_code == 4, "R6 ext halt reached", state_code, 4);
        snoop_req = 1'b1;
        step(1);
        chk(snoop_grant == 1, "R10 grant ext halt", snoop_grant, 1);
        snoop_req = 1'b0;
        brk_mgmt = 1'b1; core_halted = 2'b00;
        step(1);
        brk_mgmt = 1'b0;
        step(1);
        chk(state_code == 5 && vcode_req && !ratio_req, "R7 code restored first", state_code, 5);
        chk(vcode_val == 50, "R9 saved code", vcode_val, 50);
        for (int i = 0; i < 60 && !ratio_req; i++) @(negedge clk);
        chk(ratio_val == 20, "R9 saved ratio", ratio_val, 20);
        wait_code(0);
        chk(state_code == 0, "R7 back to normal", state_code, 0);

        // R8: wake during ratio step
        tag = "R8";
        cur_ratio = 6'd22; cur_vcode = 7'd44; low_ratio = 6'd9; low_vcode = 7'd31;
        ack_dly = 4;
        core_halted = 2'b11;
        step(1);
        step(1);
        brk_nmi = 1'b1; core_halted = 2'b00;
        step(1);
        brk_nmi = 1'b0;
        wait_code(5);
        chk(ratio_req && !vcode_req, "R8 ratio restore direct", ratio_req, 1);
        chk(ratio_val == 22, "R8 saved ratio", ratio_val, 22);
        wait_code(0);

        // R8: wake during voltage step
        core_halted = 2'b11;
        step(1);
        wait_vreq();
        core_halted = 2'b00; brk_intr = 1'b1;
        step(1);
        brk_intr = 1'b0;
        wait_code(5);
        chk(vcode_req && !ratio_req, "R8 code restore", vcode_req, 1);
        chk(vcode_val == 44, "R8 saved code", vcode_val, 44);
        wait_code(0);

        // R11: handler return
        tag = "R11";
        ext_en = 1'b0; ack_dly = 1;
        mgmt_ret_valid = 1'b1; mgmt_ret_to_halt = 1'b0;
        step(1);
        mgmt_ret_valid = 1'b0;
        step(1);
        chk(state_code == 0, "R11 return to normal", state_code, 0);
        mgmt_ret_valid = 1'b1; mgmt_ret_to_halt = 1'b1;
        step(1);
        mgmt_ret_valid = 1'b0; mgmt_ret_to_halt = 1'b0;
        step(1);
        chk(state_code == 1, "R11 return to halt", state_code, 1);
        brk_mgmt = 1'b1;
        step(1);
        brk_mgmt = 1'b0;
        step(1);
        chk(state_code == 0, "R2 wake halt", state_code, 0);

        // R3: reset mid extended entry, no clock needed
        tag = "R3";
        ext_en = 1'b1; ack_dly = 6;
        core_halted = 2'b11;
        step(1);
        step(1);
        chk(state_code == 3, "R3 pre-reset entry", state_code, 3);
        core_halted = 2'b00;
        #3 rst_n = 1'b0;
        #1;
        chk(state_code == 0 && !ratio_req && !vcode_req, "R3 async reset", state_code, 0);
        step(1);
        rst_n = 1'b1;
        step(3);
        chk(state_code == 0, "R3 after reset", state_code, 0);

        summary();
        $finish;
    end

endmodule